// File: doc/BRIEF.md
# Pixel Input Capture and 4:2:2 Deinterleave

This block sits at the digital pixel input of a video encoder. It takes up to three 8-bit input buses (`y_bus`, `c_bus`, `s_bus`). A 3-bit input-mode code says which of two output paths is live: a standard-definition path and an enhanced/high-definition path. Both paths may be live at once. Each live path turns its incoming stream into separate luma, blue-difference and red-difference samples. The samples leave with a valid strobe and an `even` flag. The `even` flag marks the luma sample that is co-sited with a fresh chroma pair.

The SD path takes a byte-serial 4:2:2 stream from one bus. The HD path takes one of four formats:

- a 16-bit 4:2:2 stream, with luma on one bus and alternating chroma on another;
- a 24-bit 4:4:4 stream, one complete pixel per clock;
- a byte-serial 4:2:2 stream at double pixel rate;
- a dual-edge stream on one bus, with luma on one clock edge and chroma on the other. A 2-bit field picks which edge carries which.

Line-start pulses re-align the chroma phase. Mode or edge codes that are not defined raise a configuration error and silence both paths.

Top module: `vin_capture`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output register is cleared: `sd_valid`, `hd_valid`, `sd_even`, `hd_even` and `cfg_err` read 0 after that edge, whatever the mode inputs hold.
- R2: `in_mode` decides which paths run:
  - 3'b000: SD only.
  - 3'b001: HD single-rate only.
  - 3'b010: HD dual-edge only.
  - 3'b011: SD with HD single-rate.
  - 3'b100: SD with HD dual-edge.
  - 3'b111: HD byte-serial only.
  - A disabled path never raises its valid strobe.
- R3: Codes 3'b101 and 3'b110 set `cfg_err` to 1 one edge later, and both valids stay 0 while `cfg_err` is 1.
- R4: Byte-serial 4:2:2 arrives as Cb, Y, Cr, Y, and so on.
  - On the edge that takes a Cr byte, the path outputs the preceding Y with that Cb and Cr, `valid`=1 and `even`=1.
  - On the edge that takes the next Y, it outputs that Y with `valid`=1, `even`=0 and the chroma held.
  - Edges that take Cb or the first Y give `valid`=0.
- R5: The byte presented in the same cycle as a line-start pulse is taken as Cb, whatever the phase before.
- R6: In 16-bit HD 4:2:2, luma comes on `y_bus` and chroma on `c_bus`, alternating Cb then Cr, with a Cb in the line-start cycle.
  - On the Cr edge, the output is the Cb-cycle luma, that Cb and that Cr, with `even`=1.
  - On the next Cb edge, the output is the Cr-cycle luma with `even`=0.
- R7: With `hd_full444`=1 in mode 3'b001, each edge outputs `y_bus`, `c_bus` and `s_bus` as Y, Cb and Cr with `valid`=1 and `even`=1. In every other mode `hd_full444` has no effect.
- R8: The SD path reads `s_bus` when `sd_bus_swap`=0 and `y_bus` when it is 1.
- R9: In dual-edge modes the HD path reads `y_bus` on both edges.
  - `ddr_edge`=2'b11 means luma is taken on the rising edge and chroma on the falling edge.
  - 2'b00 means chroma on the rising edge and luma on the falling edge.
  - The pair from one clock period is deinterleaved as in R6, one edge later than in single-rate mode, with the line-start pulse delayed to match.
- R10: In dual-edge modes, `ddr_edge` codes 2'b01 and 2'b10 set `cfg_err` to 1 and disable both paths. In other modes `ddr_edge` is ignored.
- R11: Mode 3'b111 runs the byte-serial 4:2:2 rule of R4 on `y_bus` into the HD outputs.
- R12: In the two combined modes, the SD and HD paths run at the same time, each on its own buses and with its own line-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges used in dual-edge modes |
| rst | input | 1 | Synchronous active-high reset |
| in_mode | input | 3 | Input-mode code (R2) |
| ddr_edge | input | 2 | Dual-edge luma/chroma edge assignment |
| sd_bus_swap | input | 1 | SD source bus select |
| hd_full444 | input | 1 | HD 24-bit 4:4:4 select (mode 3'b001 only) |
| sd_line_start | input | 1 | SD chroma phase re-align pulse |
| hd_line_start | input | 1 | HD chroma phase re-align pulse |
| y_bus | input | 8 | Pixel bus Y |
| c_bus | input | 8 | Pixel bus C |
| s_bus | input | 8 | Pixel bus S |
| sd_valid | output | 1 | SD sample strobe |
| sd_even | output | 1 | SD sample has fresh co-sited chroma |
| sd_y | output | 8 | SD luma |
| sd_cb | output | 8 | SD blue-difference |
| sd_cr | output | 8 | SD red-difference |
| hd_valid | output | 1 | HD sample strobe |
| hd_even | output | 1 | HD sample has fresh co-sited chroma |
| hd_y | output | 8 | HD luma |
| hd_cb | output | 8 | HD blue-difference |
| hd_cr | output | 8 | HD red-difference |
| cfg_err | output | 1 | Reserved mode or edge code seen |

## Verification
The bench goes after the chroma phase. A line-start pulse in the middle of a line must restart on Cb. A design that only counted bytes would pair Cr with the wrong luma, or emit a sample one byte early. Both dual-edge assignments are driven with distinct rising and falling values. A swapped edge mux, or a missing one-cycle realignment of line start, shows up as luma and chroma trading places or as a shifted pixel. The bench also probes reserved codes, including an edge code that must be ignored outside dual-edge modes. It probes the 4:4:4 select in a combined mode, where honouring it would corrupt the HD pixel. It probes the SD bus swap, where a design that ignored it would read the wrong bus.

// File: rtl/vin_pkg.sv
package vin_pkg;

  typedef enum logic [2:0] {
    IM_SD        = 3'b000,
    IM_HD_SDR    = 3'b001,
    IM_HD_DDR    = 3'b010,
    IM_SD_HDSDR  = 3'b011,
    IM_SD_HDDDR  = 3'b100,
    IM_RSV_A     = 3'b101,
    IM_RSV_B     = 3'b110,
    IM_HD_BYTE   = 3'b111
  } in_mode_e;

  // Which capture engines run this cycle
  typedef struct packed {
    logic sd_en;
    logic hd_sdr16;
    logic hd_ddr;
    logic hd_444;
    logic hd_byte;
    logic err;
  } path_cfg_t;

  function automatic path_cfg_t decode_mode(input logic [2:0] mode,
                                            input logic [1:0] edge_sel,
                                            input logic       want444);
    path_cfg_t c;
    c = '0;
    case (in_mode_e'(mode))
      IM_SD:       c.sd_en = 1'b1;
      IM_HD_SDR: begin
        c.hd_444   = want444;
        c.hd_sdr16 = !want444;
      end
      IM_HD_DDR:   c.hd_ddr = 1'b1;
      IM_SD_HDSDR: begin
        c.sd_en    = 1'b1;
        c.hd_sdr16 = 1'b1;
      end
      IM_SD_HDDDR: begin
        c.sd_en  = 1'b1;
        c.hd_ddr = 1'b1;
      end
      IM_HD_BYTE:  c.hd_byte = 1'b1;
      default:     c.err = 1'b1;
    endcase
    // only 2'b00 and 2'b11 are legal edge assignments in dual-edge modes
    if (c.hd_ddr && (edge_sel == 2'b01 || edge_sel == 2'b10)) begin
      c     = '0;
      c.err = 1'b1;
    end
    return c;
  endfunction

endpackage

// File: rtl/vin_deint8.sv
// Byte-serial 4:2:2 (Cb,Y,Cr,Y) splitter
module vin_deint8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         line_start,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic         even,
  output logic [W-1:0] y,
  output logic [W-1:0] cb,
  output logic [W-1:0] cr
);
  localparam logic [1:0] PH_CB = 2'd0;
  localparam logic [1:0] PH_Y0 = 2'd1;
  localparam logic [1:0] PH_CR = 2'd2;

  logic [1:0]   ph;
  logic [1:0]   eff;
  logic [W-1:0] hold_cb;
  logic [W-1:0] hold_y;

  assign eff = line_start ? PH_CB : ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_CB;
      valid   <= 1'b0;
      even    <= 1'b0;
      y       <= '0;
      cb      <= '0;
      cr      <= '0;
      hold_cb <= '0;
      hold_y  <= '0;
    end else if (!en) begin
      ph    <= PH_CB;
      valid <= 1'b0;
      even  <= 1'b0;
    end else begin
      ph    <= eff + 2'd1;
      valid <= eff[1];
      even  <= (eff == PH_CR);
      case (eff)
        PH_CB:   hold_cb <= din;
        PH_Y0:   hold_y  <= din;
        PH_CR: begin
          y  <= hold_y;
          cb <= hold_cb;
          cr <= din;
        end
        default: y <= din;
      endcase
    end
  end

  // an even sample is always followed by an odd or an idle cycle
  p_even_then_odd_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && even) |=> !even);

  // byte in the line-start cycle is Cb, so nothing comes out on the next edge
  p_restart_cb_r5: assert property (@(posedge clk) disable iff (rst)
    (en && line_start) |=> !valid);

endmodule

// File: rtl/vin_deint16.sv
// Luma + alternating chroma (one pair per clock) splitter
module vin_deint16 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         line_start,
  input  logic [W-1:0] yin,
  input  logic [W-1:0] cin,
  output logic         valid,
  output logic         even,
  output logic [W-1:0] y,
  output logic [W-1:0] cb,
  output logic [W-1:0] cr
);
  logic         ph;
  logic         eff;
  logic         pend;
  logic [W-1:0] hold_y0;
  logic [W-1:0] hold_y1;
  logic [W-1:0] hold_cb;

  assign eff = line_start ? 1'b0 : ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b0;
      pend    <= 1'b0;
      valid   <= 1'b0;
      even    <= 1'b0;
      y       <= '0;
      cb      <= '0;
      cr      <= '0;
      hold_y0 <= '0;
      hold_y1 <= '0;
      hold_cb <= '0;
    end else if (!en) begin
      ph    <= 1'b0;
      pend  <= 1'b0;
      valid <= 1'b0;
      even  <= 1'b0;
    end else begin
      ph <= !eff;
      if (!eff) begin
        // Cb cycle: store, and release the odd luma of the previous pair
        hold_y0 <= yin;
        hold_cb <= cin;
        valid   <= pend;
        even    <= 1'b0;
        pend    <= 1'b0;
        if (pend) y <= hold_y1;
      end else begin
        valid   <= 1'b1;
        even    <= 1'b1;
        y       <= hold_y0;
        cb      <= hold_cb;
        cr      <= cin;
        hold_y1 <= yin;
        pend    <= 1'b1;
      end
    end
  end

  p_pair_alt_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && even) |=> !even);

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (en && line_start) |=> !even);

endmodule

// File: rtl/vin_ddr_cap.sv
// Dual-edge capture: one register per edge, paired in the rising domain
module vin_ddr_cap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         line_start,
  input  logic         luma_on_rise,
  output logic [W-1:0] luma,
  output logic [W-1:0] chroma,
  output logic         line_start_d
);
  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q       <= '0;
      line_start_d <= 1'b0;
    end else begin
      rise_q       <= din;
      line_start_d <= line_start;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= din;
  end

  // between the falling edge and the next rising edge both halves are stable
  assign luma   = luma_on_rise ? rise_q : fall_q;
  assign chroma = luma_on_rise ? fall_q : rise_q;

endmodule

// File: rtl/vin_capture.sv
module vin_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   in_mode,
  input  logic [1:0]   ddr_edge,
  input  logic         sd_bus_swap,
  input  logic         hd_full444,
  input  logic         sd_line_start,
  input  logic         hd_line_start,
  input  logic [W-1:0] y_bus,
  input  logic [W-1:0] c_bus,
  input  logic [W-1:0] s_bus,
  output logic         sd_valid,
  output logic         sd_even,
  output logic [W-1:0] sd_y,
  output logic [W-1:0] sd_cb,
  output logic [W-1:0] sd_cr,
  output logic         hd_valid,
  output logic         hd_even,
  output logic [W-1:0] hd_y,
  output logic [W-1:0] hd_cb,
  output logic [W-1:0] hd_cr,
  output logic         cfg_err
);
  import vin_pkg::*;

  localparam logic [1:0] EDGE_LUMA_RISE = 2'b11;

  path_cfg_t cfg_d;
  path_cfg_t cfg_q;

  assign cfg_d = decode_mode(in_mode, ddr_edge, hd_full444);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  assign cfg_err = cfg_q.err;

  // SD path
  logic [W-1:0] sd_src;
  assign sd_src = sd_bus_swap ? y_bus : s_bus;

  vin_deint8 #(.W(W)) u_sd (
    .clk(clk), .rst(rst), .en(cfg_d.sd_en), .line_start(sd_line_start),
    .din(sd_src), .valid(sd_valid), .even(sd_even),
    .y(sd_y), .cb(sd_cb), .cr(sd_cr)
  );

  // HD byte-serial engine (double-rate 8-bit)
  logic         b_valid, b_even;
  logic [W-1:0] b_y, b_cb, b_cr;

  vin_deint8 #(.W(W)) u_hd_byte (
    .clk(clk), .rst(rst), .en(cfg_d.hd_byte), .line_start(hd_line_start),
    .din(y_bus), .valid(b_valid), .even(b_even),
    .y(b_y), .cb(b_cb), .cr(b_cr)
  );

  // HD dual-edge capture
  logic [W-1:0] d_luma, d_chroma;
  logic         d_ls;

  vin_ddr_cap #(.W(W)) u_ddr (
    .clk(clk), .rst(rst), .din(y_bus), .line_start(hd_line_start),
    .luma_on_rise(ddr_edge == EDGE_LUMA_RISE),
    .luma(d_luma), .chroma(d_chroma), .line_start_d(d_ls)
  );

  // HD 4:2:2 pair engine, fed by single-rate buses or the dual-edge pair
  logic         p_en, p_ls;
  logic [W-1:0] p_yin, p_cin;
  logic         w_valid, w_even;
  logic [W-1:0] w_y, w_cb, w_cr;

  assign p_en  = cfg_d.hd_sdr16 | cfg_d.hd_ddr;
  assign p_ls  = cfg_d.hd_ddr ? d_ls     : hd_line_start;
  assign p_yin = cfg_d.hd_ddr ? d_luma   : y_bus;
  assign p_cin = cfg_d.hd_ddr ? d_chroma : c_bus;

  vin_deint16 #(.W(W)) u_hd_pair (
    .clk(clk), .rst(rst), .en(p_en), .line_start(p_ls),
    .yin(p_yin), .cin(p_cin), .valid(w_valid), .even(w_even),
    .y(w_y), .cb(w_cb), .cr(w_cr)
  );

  // HD 4:4:4 full-pixel register
  logic         f_valid;
  logic [W-1:0] f_y, f_cb, f_cr;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_valid <= 1'b0;
      f_y     <= '0;
      f_cb    <= '0;
      f_cr    <= '0;
    end else begin
      f_valid <= cfg_d.hd_444;
      if (cfg_d.hd_444) begin
        f_y  <= y_bus;
        f_cb <= c_bus;
        f_cr <= s_bus;
      end
    end
  end

  // HD output select follows the configuration registered with the samples
  always_comb begin
    hd_valid = 1'b0;
    hd_even  = 1'b0;
    hd_y     = '0;
    hd_cb    = '0;
    hd_cr    = '0;
    if (cfg_q.hd_byte) begin
      hd_valid = b_valid; hd_even = b_even;
      hd_y = b_y; hd_cb = b_cb; hd_cr = b_cr;
    end else if (cfg_q.hd_sdr16 || cfg_q.hd_ddr) begin
      hd_valid = w_valid; hd_even = w_even;
      hd_y = w_y; hd_cb = w_cb; hd_cr = w_cr;
    end else if (cfg_q.hd_444) begin
      hd_valid = f_valid; hd_even = f_valid;
      hd_y = f_y; hd_cb = f_cb; hd_cr = f_cr;
    end
  end

  p_err_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!sd_valid && !hd_valid));

  p_sd_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.sd_en |-> !sd_valid);

  p_hd_even_valid_r7: assert property (@(posedge clk) disable iff (rst)
    hd_even |-> hd_valid);

endmodule

// File: tb/vin_capture_test.sv
module vin_capture_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] in_mode;
  logic [1:0] ddr_edge;
  logic       sd_bus_swap, hd_full444, sd_line_start, hd_line_start;
  logic [7:0] y_bus, c_bus, s_bus;
  logic       sd_valid, sd_even, hd_valid, hd_even, cfg_err;
  logic [7:0] sd_y, sd_cb, sd_cr, hd_y, hd_cb, hd_cr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vin_capture uut (
    .clk(clk), .rst(rst), .in_mode(in_mode), .ddr_edge(ddr_edge),
    .sd_bus_swap(sd_bus_swap), .hd_full444(hd_full444),
    .sd_line_start(sd_line_start), .hd_line_start(hd_line_start),
    .y_bus(y_bus), .c_bus(c_bus), .s_bus(s_bus),
    .sd_valid(sd_valid), .sd_even(sd_even), .sd_y(sd_y), .sd_cb(sd_cb), .sd_cr(sd_cr),
    .hd_valid(hd_valid), .hd_even(hd_even), .hd_y(hd_y), .hd_cb(hd_cb), .hd_cr(hd_cr),
    .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] edg;
    logic       swp;
    logic       w444;
    logic       ls;
    logic [7:0] yr;
    logic [7:0] yf;
    logic [7:0] c;
    logic [7:0] s;
    logic       sv;
    logic       se;
    logic [7:0] sy;
    logic [7:0] scb;
    logic [7:0] scr;
    logic       hv;
    logic       he;
    logic [7:0] hy;
    logic [7:0] hcb;
    logic [7:0] hcr;
    logic       er;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 48;
  // mode edg swp w444 ls | yr yf c s | sv se sy scb scr | hv he hy hcb hcr | er rq
  localparam vec_t TBL [0:NV-1] = '{
    // R4: SD byte stream on s_bus
    '{3'd0,2'd0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00,8'h10, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h20, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h30, 1'b1,1'b1,8'h20,8'h10,8'h30, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h21, 1'b1,1'b0,8'h21,8'h10,8'h30, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h11, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h22, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h31, 1'b1,1'b1,8'h22,8'h11,8'h31, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd4},
    // R5: line start where an odd Y was due
    '{3'd0,2'd0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00,8'h40, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd5},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h50, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd5},
    '{3'd0,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h60, 1'b1,1'b1,8'h50,8'h40,8'h60, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd5},
    // R3: reserved 101
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R8: SD from y_bus
    '{3'd0,2'd0,1'b1,1'b0,1'b1, 8'h41,8'h41,8'h00,8'hEE, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd8},
    '{3'd0,2'd0,1'b1,1'b0,1'b0, 8'h42,8'h42,8'h00,8'hEE, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd8},
    '{3'd0,2'd0,1'b1,1'b0,1'b0, 8'h43,8'h43,8'h00,8'hEE, 1'b1,1'b1,8'h42,8'h41,8'h43, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd8},
    // R3: reserved 110
    '{3'd6,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R6: HD 16-bit 4:2:2
    '{3'd1,2'd0,1'b0,1'b0,1'b1, 8'h80,8'h80,8'h90,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd6},
    '{3'd1,2'd0,1'b0,1'b0,1'b0, 8'h81,8'h81,8'hA0,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'h80,8'h90,8'hA0, 1'b0,4'd6},
    '{3'd1,2'd0,1'b0,1'b0,1'b0, 8'h82,8'h82,8'h91,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b0,8'h81,8'h90,8'hA0, 1'b0,4'd6},
    '{3'd1,2'd0,1'b0,1'b0,1'b0, 8'h83,8'h83,8'hA1,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'h82,8'h91,8'hA1, 1'b0,4'd6},
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R7: HD 4:4:4
    '{3'd1,2'd0,1'b0,1'b1,1'b0, 8'h11,8'h11,8'h22,8'h33, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'h11,8'h22,8'h33, 1'b0,4'd7},
    '{3'd1,2'd0,1'b0,1'b1,1'b0, 8'h44,8'h44,8'h55,8'h66, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'h44,8'h55,8'h66, 1'b0,4'd7},
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R12: SD plus HD single-rate, 4:4:4 select has no effect (R7)
    '{3'd3,2'd0,1'b0,1'b1,1'b1, 8'h60,8'h60,8'h70,8'h01, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd12},
    '{3'd3,2'd0,1'b0,1'b1,1'b0, 8'h61,8'h61,8'h71,8'h02, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'h60,8'h70,8'h71, 1'b0,4'd2},
    '{3'd3,2'd0,1'b0,1'b1,1'b0, 8'h62,8'h62,8'h72,8'h03, 1'b1,1'b1,8'h02,8'h01,8'h03, 1'b1,1'b0,8'h61,8'h70,8'h71, 1'b0,4'd12},
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R9: dual-edge, luma on rising edge
    '{3'd2,2'd3,1'b0,1'b0,1'b1, 8'hB0,8'hC0,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd9},
    '{3'd2,2'd3,1'b0,1'b0,1'b0, 8'hB1,8'hD0,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd9},
    '{3'd2,2'd3,1'b0,1'b0,1'b0, 8'hB2,8'hC2,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'hB0,8'hC0,8'hD0, 1'b0,4'd9},
    '{3'd2,2'd3,1'b0,1'b0,1'b0, 8'hB3,8'hD2,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b0,8'hB1,8'hC0,8'hD0, 1'b0,4'd9},
    '{3'd2,2'd3,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'hB2,8'hC2,8'hD2, 1'b0,4'd9},
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R9: dual-edge, chroma on rising edge
    '{3'd2,2'd0,1'b0,1'b0,1'b1, 8'hC5,8'hB5,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd9},
    '{3'd2,2'd0,1'b0,1'b0,1'b0, 8'hD5,8'hB6,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd9},
    '{3'd2,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'hB5,8'hC5,8'hD5, 1'b0,4'd9},
    // R10: reserved edge code in dual-edge mode, then ignored in SD mode
    '{3'd2,2'd1,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd10},
    '{3'd0,2'd1,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00,8'h70, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd10},
    '{3'd0,2'd1,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h71, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd10},
    '{3'd0,2'd1,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h72, 1'b1,1'b1,8'h71,8'h70,8'h72, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd10},
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R11: HD byte-serial on y_bus
    '{3'd7,2'd0,1'b0,1'b0,1'b1, 8'h1A,8'h1A,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd11},
    '{3'd7,2'd0,1'b0,1'b0,1'b0, 8'h2A,8'h2A,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd11},
    '{3'd7,2'd0,1'b0,1'b0,1'b0, 8'h3A,8'h3A,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,1'b1,8'h2A,8'h1A,8'h3A, 1'b0,4'd11},
    '{3'd5,2'd0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b1,4'd3},
    // R12: SD plus HD dual-edge
    '{3'd4,2'd3,1'b0,1'b0,1'b1, 8'h21,8'h31,8'h00,8'h05, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd12},
    '{3'd4,2'd3,1'b0,1'b0,1'b0, 8'h22,8'h41,8'h00,8'h06, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,1'b0,8'h00,8'h00,8'h00, 1'b0,4'd12},
    '{3'd4,2'd3,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h07, 1'b1,1'b1,8'h06,8'h05,8'h07, 1'b1,1'b1,8'h21,8'h31,8'h41, 1'b0,4'd12}
  };

  task automatic chk(input int rq, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // rising-edge value, then falling-edge value; returns after the falling edge
  task automatic step(input logic [7:0] yr, input logic [7:0] yf);
    y_bus = yr;
    @(posedge clk);
    #1;
    y_bus = yf;
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_mode = 3'd5; ddr_edge = 2'd0; sd_bus_swap = 1'b0; hd_full444 = 1'b0;
    sd_line_start = 1'b0; hd_line_start = 1'b0;
    y_bus = 8'h00; c_bus = 8'h00; s_bus = 8'h00;
    repeat (3) step(8'h00, 8'h00);
    // R1: reset state even with a reserved mode applied
    chk(1, "sd_valid in reset", {7'd0, sd_valid}, 8'h00);
    chk(1, "hd_valid in reset", {7'd0, hd_valid}, 8'h00);
    chk(1, "cfg_err in reset",  {7'd0, cfg_err},  8'h00);
    chk(1, "sd_even in reset",  {7'd0, sd_even},  8'h00);
    chk(1, "hd_even in reset",  {7'd0, hd_even},  8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_mode       = TBL[i].mode;
      ddr_edge      = TBL[i].edg;
      sd_bus_swap   = TBL[i].swp;
      hd_full444    = TBL[i].w444;
      sd_line_start = TBL[i].ls;
      hd_line_start = TBL[i].ls;
      c_bus         = TBL[i].c;
      s_bus         = TBL[i].s;
      step(TBL[i].yr, TBL[i].yf);
      chk(TBL[i].rq, $sformatf("vec %0d sd_valid", i), {7'd0, sd_valid}, {7'd0, TBL[i].sv});
      chk(TBL[i].rq, $sformatf("vec %0d hd_valid", i), {7'd0, hd_valid}, {7'd0, TBL[i].hv});
      chk(TBL[i].rq, $sformatf("vec %0d cfg_err", i),  {7'd0, cfg_err},  {7'd0, TBL[i].er});
      if (TBL[i].sv) begin
        chk(TBL[i].rq, $sformatf("vec %0d sd_even", i), {7'd0, sd_even}, {7'd0, TBL[i].se});
        chk(TBL[i].rq, $sformatf("vec %0d sd_y", i),  sd_y,  TBL[i].sy);
        chk(TBL[i].rq, $sformatf("vec %0d sd_cb", i), sd_cb, TBL[i].scb);
        chk(TBL[i].rq, $sformatf("vec %0d sd_cr", i), sd_cr, TBL[i].scr);
      end
      if (TBL[i].hv) begin
        chk(TBL[i].rq, $sformatf("vec %0d hd_even", i), {7'd0, hd_even}, {7'd0, TBL[i].he});
        chk(TBL[i].rq, $sformatf("vec %0d hd_y", i),  hd_y,  TBL[i].hy);
        chk(TBL[i].rq, $sformatf("vec %0d hd_cb", i), hd_cb, TBL[i].hcb);
        chk(TBL[i].rq, $sformatf("vec %0d hd_cr", i), hd_cr, TBL[i].hcr);
      end
    end

    // R1: reset in mid-stream clears a pending output
    in_mode = 3'd1; ddr_edge = 2'd0; sd_bus_swap = 1'b0; hd_full444 = 1'b0;
    sd_line_start = 1'b1; hd_line_start = 1'b1;
    c_bus = 8'h5C;
    step(8'h5A, 8'h5A);
    sd_line_start = 1'b0; hd_line_start = 1'b0;
    c_bus = 8'h5D;
    step(8'h5B, 8'h5B);
    chk(6, "hd_valid before mid-stream reset", {7'd0, hd_valid}, 8'h01);
    chk(6, "hd_y before mid-stream reset", hd_y, 8'h5A);
    rst = 1'b1;
    in_mode = 3'd6;
    step(8'h00, 8'h00);
    chk(1, "hd_valid after mid-stream reset", {7'd0, hd_valid}, 8'h00);
    chk(1, "cfg_err held low by reset", {7'd0, cfg_err}, 8'h00);
    chk(1, "hd_y cleared by reset", hd_y, 8'h00);
    rst = 1'b0;
    in_mode = 3'd0;
    step(8'h00, 8'h00);
    chk(1, "cfg_err after release", {7'd0, cfg_err}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule